// File: doc/BRIEF.md
# Multiplexed Event Interrupt Aggregator

This block gathers single-cycle event pulses from many sources into three banks of sticky pending flags. Each source is named by a 7-bit code. The upper two bits pick a bank and the lower five bits pick a flag within it. Each bank has three mask words, one for each of three level-sensitive interrupt lines. The high line is meant for the most urgent interrupt level, the mid line for the middle level and the low line for the least urgent.

Each line is the registered OR, over all banks, of pending AND the line's mask. The line therefore rises on the clock edge that latches a matching event. It falls only when software has cleared, or masked off, every matching flag in every bank.

Software uses a small word-addressed register port. Writing a pending word clears each flag written as 1. Writing a mask word stores the value. Reads are combinational from the current register state. Any address whose bank field is 3 reads back as zero.

Top module: `evt_irq_agg`

## Requirements
- R1: While reset is held and after it is released, every pending and mask word reads 0 and all three interrupt lines are low.
- R2: An event pulse with code bits 6:5 = b (0..2) and bits 4:0 = n sets flag n of pending bank b. The flag is readable at word address b on the cycle after the clock edge that latched it.
- R3: An event whose code bits 6:5 equal 3 changes no pending flag.
- R4: A pending flag stays set until a write clears it, whether or not further events arrive.
- R5: A write to word address b (0..2) clears every flag of bank b whose write-data bit is 1. Flags whose write-data bit is 0 are left unchanged.
- R6: When an event and a clearing write target the same flag in the same cycle, the flag ends up set.
- R7: A write stores its data directly into a mask word. Mask A of bank b sits at address 4+b, mask B at 8+b and mask C at 12+b, and each reads back what was written.
- R8: irq_hi, irq_mid and irq_lo equal the OR over all banks of pending AND mask A, mask B and mask C respectively. The value reflects the register state after the same clock edge.
- R9: After a clear, a line stays high while any other bank still holds a masked pending flag, and falls only when none remains.
- R10: Unmasking a flag that is already pending raises the matching line on the edge that stores the mask.
- R11: Reads at word addresses 3, 7, 11 and 15 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | Event pulse qualifier, one cycle per event |
| evt_code | input | 7 | Event code: bits 6:5 bank, bits 4:0 flag |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address: bits 3:2 register kind, bits 1:0 bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_hi | output | 1 | Interrupt line for masks A |
| irq_mid | output | 1 | Interrupt line for masks B |
| irq_lo | output | 1 | Interrupt line for masks C |

## Verification
A flag latched in the wrong bank or bit, or a wrongly stored mask, appears on the very next read of that word. If it overlaps any mask, it also appears on the interrupt lines one edge after the event or write. A line that keeps stale state shows up right after the clear or mask change that should have moved it. The most telling case is a clear that leaves another bank pending, where the line must not drop. A lost collision shows up as a missing flag on the readback the following cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    // number of interrupt lines, one mask word per line per bank
    localparam int LINE_CNT = 3;

    // register kind selected by bus_addr[3:2]
    typedef enum logic [1:0] {
        RK_PEND   = 2'd0,
        RK_MASK_A = 2'd1,
        RK_MASK_B = 2'd2,
        RK_MASK_C = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/evt_irq_decode.sv
// Turns an event code into per-bank set vectors.
module evt_irq_decode #(
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 3,
    localparam int BIT_W    = $clog2(BANK_W),
    localparam int CODE_W   = BIT_W + 2
) (
    input  logic                                evt_valid,
    input  logic [CODE_W-1:0]                   evt_code,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]    set_vec
);
    logic [1:0]       bank_sel;
    logic [BIT_W-1:0] bit_sel;
    logic [BANK_W-1:0] one_hot;

    assign bank_sel = evt_code[CODE_W-1 -: 2];
    assign bit_sel  = evt_code[BIT_W-1:0];

    always_comb begin
        one_hot = '0;
        one_hot[bit_sel] = 1'b1;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign set_vec[b] = (evt_valid && (bank_sel == 2'(b))) ? one_hot : '0;
    end
endmodule

// File: rtl/evt_irq_regsel.sv
// Decodes the word address into per-bank write strobes and a mapped flag.
module evt_irq_regsel
    import evt_irq_pkg::*;
#(
    parameter int NUM_BANKS = 3
) (
    input  logic                                  bus_we,
    input  logic [3:0]                            bus_addr,
    output reg_kind_e                             kind,
    output logic [1:0]                            bank_idx,
    output logic                                  mapped,
    output logic [NUM_BANKS-1:0]                  clr_we,
    output logic [NUM_BANKS-1:0][LINE_CNT-1:0]    mask_we
);
    localparam logic [1:0] BANK_LIM = 2'(NUM_BANKS);

    assign kind     = reg_kind_e'(bus_addr[3:2]);
    assign bank_idx = bus_addr[1:0];
    assign mapped   = (bank_idx < BANK_LIM);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic hit;
        assign hit       = bus_we && (bank_idx == 2'(b));
        assign clr_we[b] = hit && (kind == RK_PEND);
        for (genvar l = 0; l < LINE_CNT; l++) begin : g_line
            assign mask_we[b][l] = hit && (kind == reg_kind_e'(l + 1));
        end
    end
endmodule

// File: rtl/evt_irq_bank.sv
// One pending word with its three mask words.
module evt_irq_bank
    import evt_irq_pkg::*;
#(
    parameter int BANK_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [BANK_W-1:0]                 set_bits,
    input  logic                              clr_we,
    input  logic [LINE_CNT-1:0]               mask_we,
    input  logic [BANK_W-1:0]                 wdata,
    output logic [BANK_W-1:0]                 pend_q_o,
    output logic [LINE_CNT-1:0][BANK_W-1:0]   mask_q_o,
    output logic [LINE_CNT-1:0]               hit_d_o
);
    typedef struct packed {
        logic [BANK_W-1:0]               pend;
        logic [LINE_CNT-1:0][BANK_W-1:0] mask;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, then set: an event beats a same-cycle clear
        if (clr_we) begin
            st_d.pend = st_q.pend & ~wdata;
        end
        st_d.pend = st_d.pend | set_bits;
        for (int l = 0; l < LINE_CNT; l++) begin
            if (mask_we[l]) begin
                st_d.mask[l] = wdata;
            end
        end
        for (int l = 0; l < LINE_CNT; l++) begin
            hit_d_o[l] = |(st_d.pend & st_d.mask[l]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q_o = st_q.pend;
    assign mask_q_o = st_q.mask;
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
    import evt_irq_pkg::*;
#(
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 3,
    localparam int CODE_W   = $clog2(BANK_W) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [CODE_W-1:0] evt_code,
    input  logic              bus_we,
    input  logic [3:0]        bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_hi,
    output logic              irq_mid,
    output logic              irq_lo
);
    logic [NUM_BANKS-1:0][BANK_W-1:0]               set_vec;
    logic [NUM_BANKS-1:0][BANK_W-1:0]               pend_all;
    logic [NUM_BANKS-1:0][LINE_CNT-1:0][BANK_W-1:0] mask_all;
    logic [NUM_BANKS-1:0][LINE_CNT-1:0]             hit_d;
    logic [NUM_BANKS-1:0]                           clr_we;
    logic [NUM_BANKS-1:0][LINE_CNT-1:0]             mask_we;
    reg_kind_e                                      kind;
    logic [1:0]                                     bank_idx;
    logic                                           mapped;

    typedef struct packed {
        logic [LINE_CNT-1:0] irq;
    } out_st_t;

    out_st_t out_d, out_q;

    evt_irq_decode #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) decode_i (
        .evt_valid (evt_valid),
        .evt_code  (evt_code),
        .set_vec   (set_vec)
    );

    evt_irq_regsel #(.NUM_BANKS(NUM_BANKS)) regsel_i (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .kind     (kind),
        .bank_idx (bank_idx),
        .mapped   (mapped),
        .clr_we   (clr_we),
        .mask_we  (mask_we)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        evt_irq_bank #(.BANK_W(BANK_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_bits (set_vec[b]),
            .clr_we   (clr_we[b]),
            .mask_we  (mask_we[b]),
            .wdata    (bus_wdata),
            .pend_q_o (pend_all[b]),
            .mask_q_o (mask_all[b]),
            .hit_d_o  (hit_d[b])
        );
    end

    // line levels: OR across every bank of the next-state hits
    always_comb begin
        out_d = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            out_d.irq = out_d.irq | hit_d[b];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // read mux from current state
    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            if (kind == RK_PEND) begin
                bus_rdata = pend_all[bank_idx];
            end else begin
                bus_rdata = mask_all[bank_idx][2'(kind) - 2'd1];
            end
        end
    end

    assign irq_hi  = out_q.irq[0];
    assign irq_mid = out_q.irq[1];
    assign irq_lo  = out_q.irq[2];
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
    parameter int BANK_W    = 32,
    parameter int NUM_BANKS = 3,
    localparam int CODE_W   = $clog2(BANK_W) + 2
) (
    input logic                                     clk,
    input logic                                     rst_n,
    input logic                                     evt_valid,
    input logic [CODE_W-1:0]                        evt_code,
    input logic                                     bus_we,
    input logic [3:0]                               bus_addr,
    input logic [BANK_W-1:0]                        bus_rdata,
    input logic                                     irq_hi,
    input logic                                     irq_mid,
    input logic                                     irq_lo,
    input logic [NUM_BANKS-1:0][BANK_W-1:0]         pend_all,
    input logic [NUM_BANKS-1:0][2:0][BANK_W-1:0]    mask_all
);
    logic [2:0] lvl;
    always_comb begin
        lvl = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            for (int l = 0; l < 3; l++) begin
                lvl[l] = lvl[l] | (|(pend_all[b] & mask_all[b][l]));
            end
        end
    end

    logic clr_wr;
    assign clr_wr = bus_we && (bus_addr[3:2] == 2'd0);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_wr |=> ((pend_all & $past(pend_all)) == $past(pend_all)));

    p_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_code[CODE_W-1 -: 2] == 2'd3 && !clr_wr) |=> $stable(pend_all));

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_code[CODE_W-1 -: 2] != 2'd3) |=>
        pend_all[$past(evt_code[CODE_W-1 -: 2])][$past(evt_code[CODE_W-3:0])]);

    p_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        {irq_lo, irq_mid, irq_hi} == lvl);

    p_unmapped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[1:0] == 2'd3) |-> (bus_rdata == '0));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_code  (evt_code),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq_hi    (irq_hi),
    .irq_mid   (irq_mid),
    .irq_lo    (irq_lo),
    .pend_all  (pend_all),
    .mask_all  (mask_all)
);

// File: tb/evt_irq_agg_tb_top.sv
`timescale 1ns/1ps
module evt_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [6:0]  evt_code = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_hi, irq_mid, irq_lo;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [31:0] m_pend [3];
    logic [31:0] m_mask [3][3];

    always #2 clk = ~clk;

    evt_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_hi(irq_hi), .irq_mid(irq_mid), .irq_lo(irq_lo)
    );

    function automatic logic exp_line(int l);
        logic r = 1'b0;
        for (int b = 0; b < 3; b++) r = r | (|(m_pend[b] & m_mask[b][l]));
        return r;
    endfunction

    function automatic logic [31:0] exp_read(logic [3:0] a);
        if (a[1:0] == 2'd3) return 32'h0;
        if (a[3:2] == 2'd0) return m_pend[a[1:0]];
        return m_mask[a[1:0]][a[3:2] - 2'd1];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_lines(string req);
        chk(req, {29'b0, irq_lo, irq_mid, irq_hi},
            {29'b0, exp_line(2), exp_line(1), exp_line(0)});
    endtask

    // one clock: drive, let the edge pass, update model, check lines
    task automatic step(logic v, logic [6:0] code, logic we, logic [3:0] a,
                        logic [31:0] d, string req);
        evt_valid = v; evt_code = code; bus_we = we; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        if (we && a[1:0] != 2'd3) begin
            if (a[3:2] == 2'd0) m_pend[a[1:0]] = m_pend[a[1:0]] & ~d;
            else m_mask[a[1:0]][a[3:2] - 2'd1] = d;
        end
        if (v && code[6:5] != 2'd3) m_pend[code[6:5]][code[4:0]] = 1'b1;
        chk_lines(req);
        @(negedge clk);
        evt_valid = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, string req);
        bus_addr = a; bus_we = 1'b0;
        #1;
        chk(req, bus_rdata, exp_read(a));
    endtask

    task automatic idle(string req);
        step(1'b0, 7'd0, 1'b0, 4'd3, 32'd0, req);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < 3; b++) begin
            m_pend[b] = '0;
            for (int l = 0; l < 3; l++) m_mask[b][l] = '0;
        end
        void'($urandom(32'h1A2B3C4D));
        repeat (3) @(negedge clk);
        chk_lines("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 16; a++) rd(4'(a), "R1 reset readback");

        // R2: set flag 7 in bank 1, then R7 masks
        step(1'b1, {2'd1, 5'd7}, 1'b0, 4'd0, 32'd0, "R2 event");
        rd(4'd1, "R2 bank1 flag7");
        rd(4'd0, "R2 bank0 untouched");
        // R3: bank code 3 ignored
        step(1'b1, {2'd3, 5'd4}, 1'b0, 4'd0, 32'd0, "R3 event");
        for (int a = 0; a < 3; a++) rd(4'(a), "R3 no flag changed");
        // R7 mask storage
        step(1'b0, 7'd0, 1'b1, 4'd4, 32'h0000_0080, "R8 maskA bank0");
        rd(4'd4, "R7 maskA bank0");
        step(1'b0, 7'd0, 1'b1, 4'd9, 32'hDEAD_BEEF, "R8 maskB bank1");
        rd(4'd9, "R7 maskB bank1");
        chk("R8 mid raised", {31'b0, irq_mid}, 32'd1);
        // R10: unmask already-pending flag
        step(1'b1, {2'd2, 5'd3}, 1'b0, 4'd0, 32'd0, "R10 pend bank2");
        chk("R10 lo low before unmask", {31'b0, irq_lo}, 32'd0);
        step(1'b0, 7'd0, 1'b1, 4'd14, 32'h0000_0008, "R10 unmask");
        chk("R10 lo after unmask", {31'b0, irq_lo}, 32'd1);
        // R9: two banks feeding mask A
        step(1'b0, 7'd0, 1'b1, 4'd5, 32'h0000_0080, "R9 maskA bank1");
        step(1'b1, {2'd0, 5'd7}, 1'b0, 4'd0, 32'd0, "R9 pend bank0");
        step(1'b0, 7'd0, 1'b1, 4'd0, 32'hFFFF_FFFF, "R9 clear bank0");
        chk("R9 hi held by bank1", {31'b0, irq_hi}, 32'd1);
        step(1'b0, 7'd0, 1'b1, 4'd1, 32'h0000_0080, "R9 clear bank1");
        chk("R9 hi dropped", {31'b0, irq_hi}, 32'd0);
        // R5: partial clear
        step(1'b1, {2'd2, 5'd10}, 1'b0, 4'd0, 32'd0, "R5 setup");
        step(1'b0, 7'd0, 1'b1, 4'd2, 32'h0000_0008, "R5 clear");
        rd(4'd2, "R5 only written bit cleared");
        // R6: collision
        step(1'b1, {2'd1, 5'd5}, 1'b1, 4'd1, 32'hFFFF_FFFF, "R6 collide");
        rd(4'd1, "R6 event wins");
        // R4: sticky across idle cycles
        repeat (3) idle("R4 idle");
        rd(4'd1, "R4 sticky");
        // R11
        for (int a = 3; a < 16; a += 4) rd(4'(a), "R11 unmapped");

        // random mix
        for (int i = 0; i < 600; i++) begin
            logic [3:0]  a = 4'($urandom_range(0, 15));
            logic [31:0] d = $urandom() & $urandom();
            logic        v = ($urandom_range(0, 3) != 0);
            logic        w = ($urandom_range(0, 3) == 0);
            step(v, 7'($urandom()), w, a, d, "R8 random lines");
            rd(4'($urandom_range(0, 15)), "R2 R5 R7 random readback");
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule